// File: doc/BRIEF.md
# Comma Aligner with Polarity Inversion

This block sits on the receive side of a serial link, after the deserializer. Each clock it takes one raw 10-bit word, whose boundaries are arbitrary relative to the real code groups. It searches the recent stream for the 8b/10b comma, which is K28.5 in either running disparity. Once it trusts a boundary, it delivers aligned 10-bit code groups together with a lock flag that tells the link layer the data is usable.

A polarity input lets the link layer correct a receiver whose differential pair is wired backwards. When it is set, every incoming bit is complemented before the alignment search. Changing the polarity throws away any lock held so far, because the alignment found under the old polarity no longer applies.

Lock is only declared after two commas are seen at the same bit offset. The offset is then frozen. Lock is released after a parameterised run of consecutive code groups that fail a simple validity test, and the search then begins again.

Top module: `comma_align`

## Requirements
- R1: While `rst` is high at a rising clock edge, `lock_o` and `sym_o` read zero after that edge.
- R2: Bit 9 of `raw_i` is the earliest received bit. A comma is either 0011111010 or 1100000101, read earliest bit first, and it is recognised at any of the 10 bit offsets.
- R3: Edge n is the edge that captures `raw_i` word n. If the confirming comma begins in word m, `lock_o` is first high after edge m+3.
- R4: A single comma, with no second comma at the same offset, never raises `lock_o`.
- R5: While `lock_o` is high, the value of `sym_o` after edge t is the code group that begins in word t-2 at the locked offset, with bit 9 as the earliest bit.
- R6: Once locked, the offset is frozen. A comma pattern that appears at a different offset does not change the alignment of `sym_o`.
- R7: A code group is invalid if it holds fewer than 4 or more than 6 ones. If LOSS_LIM consecutive aligned groups are invalid and the first of them begins in word a, `lock_o` is high after edge a+LOSS_LIM+1 and low after edge a+LOSS_LIM+2. The comma search then restarts, and two new commas relock as in R3.
- R8: A run of LOSS_LIM-1 invalid groups followed by a valid one keeps `lock_o` high.
- R9: When `invert_i` is high for the edge that captures a word, all ten bits of that word are complemented before alignment. A received D21.5 (1010101010) stream is therefore delivered as D10.2 (0101010101).
- R10: If `invert_i` at edge p differs from its value at edge p-1, `lock_o` is low after edge p+1, and lock has to be reacquired through R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, one raw word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 10 | Raw deserialized word, bit 9 received first |
| invert_i | input | 1 | Complement every received bit when high |
| sym_o | output | 10 | Aligned code group, bit 9 first |
| lock_o | output | 1 | Symbol lock; `sym_o` is valid when high |

## Verification
The bench builds code-group streams at a random bit offset, with both comma forms placed at known words. It checks the exact cycle in which lock rises. A design that counted one register too many or too few, or that locked on the first comma, is caught at that edge.

The bench then places two valid groups whose junction forms a comma at a shifted offset. A design that re-aligned while locked would deliver corrupted groups at that point.

Runs of invalid groups are sent with length LOSS_LIM and with length LOSS_LIM-1, to expose an off-by-one in the loss counter. A later pair of commas shows whether the search really restarts.

Finally, the polarity is flipped under a D21.5 stream. A design that kept its lock, or failed to complement the bits, would show the wrong lock timing or D21.5 where D10.2 is expected.

// File: rtl/cma_pkg.sv
package cma_pkg;
  localparam int SYM_W = 10;
  localparam int OFF_W = $clog2(SYM_W);
  localparam int WIN_W = 2 * SYM_W - 1;

  localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_st_e;

  function automatic logic group_ok(input logic [SYM_W-1:0] g);
    int ones;
    ones = 0;
    for (int i = 0; i < SYM_W; i++) ones += int'(g[i]);
    return (ones >= 4) && (ones <= 6);
  endfunction
endpackage

// File: rtl/cma_front.sv
module cma_front
  import cma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] raw_i,
  input  logic             invert_i,
  output logic [WIN_W-1:0] win_o,
  output logic             pol_chg_o
);
  logic [SYM_W-1:0] cur_q;
  logic [SYM_W-1:0] prev_q;
  logic             pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      prev_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      cur_q  <= raw_i ^ {SYM_W{invert_i}};
      prev_q <= cur_q;
      pol_q  <= invert_i;
    end
  end

  assign pol_chg_o = invert_i ^ pol_q;
  assign win_o     = {prev_q, cur_q[SYM_W-1:1]};
endmodule

// File: rtl/cma_scan.sv
module cma_scan
  import cma_pkg::*;
(
  input  logic [WIN_W-1:0] win_i,
  input  logic [OFF_W-1:0] sel_i,
  output logic [SYM_W-1:0] hits_o,
  output logic             any_o,
  output logic [OFF_W-1:0] first_o,
  output logic [SYM_W-1:0] aligned_o
);
  logic [SYM_W-1:0] cand [SYM_W];

  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    assign cand[k]   = win_i[WIN_W-1-k -: SYM_W];
    assign hits_o[k] = (cand[k] == COMMA_NEG) || (cand[k] == COMMA_POS);
  end

  assign any_o = |hits_o;

  always_comb begin
    first_o = '0;
    for (int k = SYM_W - 1; k >= 0; k--)
      if (hits_o[k]) first_o = OFF_W'(k);
  end

  always_comb begin
    aligned_o = cand[0];
    for (int k = 1; k < SYM_W; k++)
      if (sel_i == OFF_W'(k)) aligned_o = cand[k];
  end
endmodule

// File: rtl/cma_lock.sv
module cma_lock
  import cma_pkg::*;
#(
  parameter int LOSS_LIM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pol_chg_i,
  input  logic [SYM_W-1:0] hits_i,
  input  logic             any_i,
  input  logic [OFF_W-1:0] first_i,
  input  logic             grp_ok_i,
  output lock_st_e         st_o,
  output logic [OFF_W-1:0] off_o
);
  localparam int CNT_W = (LOSS_LIM > 1) ? $clog2(LOSS_LIM) : 1;

  lock_st_e         st_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] bad_q;
  logic             hit_here;

  always_comb begin
    hit_here = 1'b0;
    for (int k = 0; k < SYM_W; k++)
      if (off_q == OFF_W'(k)) hit_here = hits_i[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_HUNT;
      off_q <= '0;
      bad_q <= '0;
    end else if (pol_chg_i) begin
      st_q  <= ST_HUNT;
      bad_q <= '0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          bad_q <= '0;
          if (any_i) begin
            off_q <= first_i;
            st_q  <= ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (hit_here)   st_q  <= ST_LOCKED;
          else if (any_i) off_q <= first_i;
        end
        ST_LOCKED: begin
          if (grp_ok_i) begin
            bad_q <= '0;
          end else if (bad_q == CNT_W'(LOSS_LIM - 1)) begin
            bad_q <= '0;
            st_q  <= ST_HUNT;
          end else begin
            bad_q <= bad_q + 1'b1;
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  assign st_o  = st_q;
  assign off_o = off_q;
endmodule

// File: rtl/comma_align.sv
module comma_align
  import cma_pkg::*;
#(
  parameter int LOSS_LIM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] raw_i,
  input  logic             invert_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             lock_o
);
  logic [WIN_W-1:0] win;
  logic             pol_chg;
  logic [SYM_W-1:0] hits;
  logic             any_hit;
  logic [OFF_W-1:0] first_off;
  logic [SYM_W-1:0] aligned;
  lock_st_e         st_q;
  logic [OFF_W-1:0] off_q;

  cma_front u_front (
    .clk(clk), .rst(rst), .raw_i(raw_i), .invert_i(invert_i),
    .win_o(win), .pol_chg_o(pol_chg)
  );

  cma_scan u_scan (
    .win_i(win), .sel_i(off_q), .hits_o(hits), .any_o(any_hit),
    .first_o(first_off), .aligned_o(aligned)
  );

  cma_lock #(.LOSS_LIM(LOSS_LIM)) u_lock (
    .clk(clk), .rst(rst), .pol_chg_i(pol_chg), .hits_i(hits),
    .any_i(any_hit), .first_i(first_off), .grp_ok_i(group_ok(aligned)),
    .st_o(st_q), .off_o(off_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o  <= '0;
      lock_o <= 1'b0;
    end else begin
      sym_o  <= aligned;
      lock_o <= (st_q == ST_LOCKED);
    end
  end
endmodule

// File: rtl/cma_chk.sv
module cma_chk
  import cma_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             invert_i,
  input logic             lock_o,
  input logic [SYM_W-1:0] sym_o,
  input lock_st_e         st,
  input logic [OFF_W-1:0] off
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!lock_o && sym_o == '0));

  // R10
  pol_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (invert_i != $past(invert_i)) |=> ##1 !lock_o);

  // R6
  off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCKED && $past(st) == ST_LOCKED) |-> $stable(off));

  // R4
  lock_via_confirm_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOCKED && $past(st) != ST_LOCKED) |-> ($past(st) == ST_CONFIRM));

  // R3
  lock_follows_state_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> ($past(st) == ST_LOCKED));
endmodule

bind comma_align cma_chk u_chk (
  .clk(clk), .rst(rst), .invert_i(invert_i), .lock_o(lock_o),
  .sym_o(sym_o), .st(st_q), .off(off_q)
);

// File: tb/comma_align_tb.sv
module comma_align_tb;
  localparam int LIM = 4;
  localparam int NW  = 44;
  localparam logic [9:0] KN  = 10'b0011111010;
  localparam logic [9:0] KP  = 10'b1100000101;
  localparam logic [9:0] D21 = 10'b1010101010;
  localparam logic [9:0] G1  = 10'b1010100111;
  localparam logic [9:0] G2  = 10'b1101010101;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] raw_i = '0;
  logic       invert_i = 1'b0;
  logic [9:0] sym_o;
  logic       lock_o;

  int total = 0;
  int bad = 0;

  logic [9:0] grp [0:47];
  bit         invs [0:47];
  bit         exp_lk [0:47];
  string      tag [0:47];
  int         shft;

  always #10 clk = ~clk;

  comma_align #(.LOSS_LIM(LIM)) u_dut (
    .clk(clk), .rst(rst), .raw_i(raw_i), .invert_i(invert_i),
    .sym_o(sym_o), .lock_o(lock_o)
  );

  function automatic logic [9:0] data_grp(int sel);
    case (sel % 4)
      0: return 10'b1010101010;
      1: return 10'b0101010101;
      2: return 10'b1100110011;
      default: return 10'b0011001101;
    endcase
  endfunction

  function automatic logic bit_at(int p);
    int q;
    if (p < shft) return p[0];
    q = p - shft;
    return grp[q / 10][9 - (q % 10)];
  endfunction

  function automatic logic [9:0] word_at(int j);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) w[9-i] = bit_at(10 * j + i);
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [9:0] act, logic [9:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic check_at(int t);
    logic [9:0] es;
    check(lock_o == exp_lk[t], tag[t], {9'd0, lock_o}, {9'd0, exp_lk[t]});
    if (exp_lk[t] && t >= 2) begin
      es = grp[t-2] ^ {10{invs[t-2]}};
      check(sym_o == es, (t >= 12 && t <= 14) ? "R6 sym" : "R5 R9 sym", sym_o, es);
    end
  endtask

  task automatic run_stream();
    rst = 1'b1;
    invert_i = 1'b0;
    raw_i = '0;
    repeat (2) @(negedge clk);
    check(lock_o == 1'b0 && sym_o == '0, "R1 reset", sym_o, 10'd0);
    for (int t = 0; t < NW; t++) begin
      if (t > 0) check_at(t - 1);
      rst = 1'b0;
      raw_i = word_at(t);
      invert_i = invs[t];
      @(negedge clk);
    end
    check_at(NW - 1);
  endtask

  task automatic build_rand(bit full);
    for (int g = 0; g < 48; g++) begin
      grp[g] = data_grp(int'($urandom % 4));
      invs[g] = 1'b0;
    end
    grp[3]  = ($urandom % 2) ? KN : KP;
    grp[6]  = ($urandom % 2) ? KN : KP;
    grp[10] = G1;
    grp[11] = G2;
    for (int i = 0; i < (full ? LIM : LIM - 1); i++) grp[15 + i] = 10'h3FF;
    grp[25] = ($urandom % 2) ? KN : KP;
    grp[28] = ($urandom % 2) ? KN : KP;
    for (int t = 0; t < 48; t++) begin
      exp_lk[t] = (t >= 9) && (!full || t <= 20 || t >= 31);
      if (t < 9)                   tag[t] = "R4 lock";
      else if (t == 9)             tag[t] = "R2 R3 lock";
      else if (full && t >= 20 && t <= 30) tag[t] = "R7 lock";
      else if (!full && t >= 16 && t <= 22) tag[t] = "R8 lock";
      else if (t == 31)            tag[t] = "R7 relock";
      else                         tag[t] = "R3 lock";
    end
  endtask

  task automatic build_pol();
    for (int g = 0; g < 48; g++) grp[g] = D21;
    grp[3]  = KN;
    grp[6]  = KN;
    grp[16] = KN;
    grp[19] = KN;
    for (int t = 0; t < 48; t++) begin
      invs[t]   = (t >= 12);
      exp_lk[t] = (t >= 9 && t <= 12) || (t >= 22);
      tag[t]    = (t >= 12 && t <= 22) ? "R10 lock" : "R3 lock";
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int tr = 0; tr < 12; tr++) begin
      shft = (tr < 10) ? tr : int'($urandom % 10);
      build_rand(tr % 2 == 0);
      run_stream();
    end
    shft = int'($urandom % 10);
    build_pol();
    run_stream();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule